// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the oversampling enable for a serial transmitter and receiver from the peripheral clock. Software programs a 16-bit integer divisor and a one-byte fraction that holds an additive numerator and a multiplier denominator. The block then emits a one-clock enable pulse whose long-run rate is `f_clk / (D * (1 + A/M))`. Sixteen such pulses make one bit time, so the bit rate is that value over sixteen. Software chooses the divisor values; the block only carries out the division it is given.

The integer divisor counts out a base interval. A small phase accumulator adds the numerator once per interval. Whenever the sum reaches the denominator, the interval being started is doubled, which yields non-integer average ratios. The divisor bytes are guarded by an access bit in a control byte. Any accepted write to a divisor byte or to the fraction byte restarts the counter and the phase, so a period never mixes old and new settings.

The configuration port is a plain single-cycle write strobe with no back-pressure: a write is taken on every clock edge where `cfg_we` is high. The tick output is a plain enable with no handshake, because consumers sample it on every clock.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is held, `baud_tick` is low. After release, the defaults are divisor 1, fraction off and access bit clear. `baud_tick` is low in the first cycle after release and high in every cycle from the second one on.
- R2: With the fraction off, ticks come exactly D clocks apart, where D is the programmed 16-bit divisor.
- R3: A programmed divisor of zero behaves as a divisor of one.
- R4: With a valid fraction (numerator A, denominator M), the phase starts at 0 on every restart. Each interval adds A to the phase first. If the sum is M or more, that interval lasts 2·D clocks and the phase becomes sum−M. Otherwise it lasts D clocks and the phase becomes the sum.
- R5: When the effective numerator is nonzero and the divisor is below 2, a divisor of 2 is used.
- R6: A fraction with M = 0, or with A ≥ M, is treated as fraction off (A = 0, M = 1).
- R7: Register select `cfg_addr`: 0 is divisor bits 7:0, 1 is divisor bits 15:8, 2 is the fraction byte, 3 is control. In the fraction byte, A is bits 3:0 and M is bits 7:4. In the control byte, bit 7 is the divisor access bit.
- R8: Writes to select 0 or 1 while the access bit is clear change nothing and do not disturb the running tick sequence.
- R9: An accepted write to select 0, 1 or 2 restarts generation. The first tick appears L+1 clocks after the write edge, where L is the first interval length under R4. No tick is produced in between.
- R10: When the effective divisor is at least 2, every tick is exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select (R7) |
| cfg_wdata | input | 8 | Configuration write byte |
| baud_tick | output | 1 | One-clock oversampling enable |

## Verification
The assertions check the following on every cycle:
- The phase never reaches the denominator.
- The interval counter stays below twice the effective divisor.
- A restart is followed by a quiet cycle.
- A tick with divisor two or more lasts one clock.
- A locked divisor write leaves the divisor unchanged.

The exact placement of ticks can be shown only by the bench scenarios. These cover the doubled-interval pattern of a fraction, the clamps for a zero divisor and for a small divisor with a fraction, the fallback for an invalid fraction, the delay of the first tick after a restart, and an unbroken sequence across locked writes.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    SEL_DIV_LO = 2'd0,
    SEL_DIV_HI = 2'd1,
    SEL_FRAC   = 2'd2,
    SEL_CTRL   = 2'd3
  } cfg_sel_e;
  localparam int ACCESS_BIT = 7;
endpackage

// File: rtl/fbg_cfg_regs.sv
module fbg_cfg_regs
  import fbg_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [7:0]        wdata,
  output logic              restart,
  output logic [DIV_W-1:0]  eff_div,
  output logic [FRAC_W-1:0] eff_add,
  output logic [FRAC_W-1:0] eff_mul
);
  localparam int HI_W = DIV_W - 8;

  logic [DIV_W-1:0]    div_q;
  logic [2*FRAC_W-1:0] frac_q;
  logic                access_q;
  cfg_sel_e            sel_e;
  logic                div_ok;

  assign sel_e  = cfg_sel_e'(sel);
  assign div_ok = we && access_q && (sel_e == SEL_DIV_LO || sel_e == SEL_DIV_HI);
  assign restart = div_ok || (we && sel_e == SEL_FRAC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= DIV_W'(1);
      frac_q   <= {FRAC_W'(1), FRAC_W'(0)};
      access_q <= 1'b0;
    end else if (we) begin
      unique case (sel_e)
        SEL_DIV_LO: if (access_q) div_q[7:0] <= wdata;
        SEL_DIV_HI: if (access_q) div_q[DIV_W-1:8] <= wdata[HI_W-1:0];
        SEL_FRAC:   frac_q <= wdata[2*FRAC_W-1:0];
        SEL_CTRL:   access_q <= wdata[ACCESS_BIT];
        default: ;
      endcase
    end
  end

  logic [FRAC_W-1:0] raw_mul, raw_add;
  logic              bad_frac;
  logic [DIV_W-1:0]  base_div;

  always_comb begin
    raw_add  = frac_q[FRAC_W-1:0];
    raw_mul  = frac_q[2*FRAC_W-1:FRAC_W];
    bad_frac = (raw_mul == '0) || (raw_add >= raw_mul);
    eff_mul  = bad_frac ? FRAC_W'(1) : raw_mul;
    eff_add  = bad_frac ? '0 : raw_add;
    base_div = (div_q == '0) ? DIV_W'(1) : div_q;
    eff_div  = ((eff_add != '0) && (base_div < DIV_W'(2))) ? DIV_W'(2) : base_div;
  end

  // R8: divisor bytes stay put while the access bit is clear
  p_div_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !access_q && (sel_e == SEL_DIV_LO || sel_e == SEL_DIV_HI)) |=> $stable(div_q));
endmodule

// File: rtl/fbg_phase.sv
module fbg_phase #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [FRAC_W-1:0] add,
  input  logic [FRAC_W-1:0] mul,
  output logic              stretch
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc_q;
  logic [SUM_W-1:0]  sum, wrapped;

  assign sum     = {1'b0, acc_q} + {1'b0, add};
  assign stretch = sum >= {1'b0, mul};
  assign wrapped = sum - {1'b0, mul};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) acc_q <= '0;
    else if (step)       acc_q <= stretch ? wrapped[FRAC_W-1:0] : sum[FRAC_W-1:0];
  end

  // R4: the phase residue is always below the denominator
  p_acc_below_mul_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < mul);
endmodule

// File: rtl/fbg_tick_ctr.sv
module fbg_tick_ctr #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] eff_div,
  input  logic             stretch,
  output logic             step,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q, len;
  logic             pend_q, tick_q;

  assign step = !restart && (pend_q || cnt_q == '0);
  assign len  = stretch ? {eff_div, 1'b0} : {1'b0, eff_div};
  assign tick = tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (restart) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (step) begin
      cnt_q  <= len - CNT_W'(1);
      tick_q <= !pend_q;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_q - CNT_W'(1);
      tick_q <= 1'b0;
    end
  end

  // R9: a restart is always followed by a quiet cycle
  p_restart_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick_q);
  // R10: ticks are one clock wide once the divisor is at least two
  p_tick_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && eff_div >= DIV_W'(2)) |=> !tick_q);
  // R4: the interval counter never exceeds a doubled interval
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < {eff_div, 1'b0});
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic             baud_tick
);
  logic              restart, step, stretch;
  logic [DIV_W-1:0]  eff_div;
  logic [FRAC_W-1:0] eff_add, eff_mul;

  fbg_cfg_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_addr), .wdata(cfg_wdata),
    .restart(restart), .eff_div(eff_div), .eff_add(eff_add), .eff_mul(eff_mul)
  );

  fbg_phase #(.FRAC_W(FRAC_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .clear(restart), .step(step),
    .add(eff_add), .mul(eff_mul), .stretch(stretch)
  );

  fbg_tick_ctr #(.DIV_W(DIV_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .restart(restart), .eff_div(eff_div),
    .stretch(stretch), .step(step), .tick(baud_tick)
  );

  // R1: no tick while reset is applied
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !baud_tick);
endmodule

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       baud_tick;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int acc_m;

  always #2 clk = ~clk;

  frac_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .baud_tick(baud_tick)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; consumes one cycle
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic expect_gap(input int g, input string req);
    int n = 0;
    bit found = 0;
    while (!found && n < g + 4) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (baud_tick) found = 1;
    end
    chk(found && n == g, req, n, g);
  endtask

  function automatic int model_div(input int dl, input logic [7:0] fr, output int a, output int m);
    int d;
    m = fr[7:4];
    a = fr[3:0];
    if (m == 0 || a >= m) begin a = 0; m = 1; end
    d = (dl == 0) ? 1 : dl;
    if (a != 0 && d < 2) d = 2;
    return d;
  endfunction

  function automatic int next_len(input int d, input int a, input int m);
    int s = acc_m + a;
    if (s >= m) begin acc_m = s - m; return 2 * d; end
    acc_m = s;
    return d;
  endfunction

  task automatic program_and_check(input int dl, input logic [7:0] fr, input int periods, input string req);
    int a, m, d;
    wr(2'd3, 8'h80);
    wr(2'd0, dl[7:0]);
    wr(2'd1, dl[15:8]);
    wr(2'd2, fr);
    d = model_div(dl, fr, a, m);
    acc_m = 0;
    expect_gap(next_len(d, a, m) + 1, {req, "/R9"});
    for (int i = 1; i < periods; i++) expect_gap(next_len(d, a, m), req);
  endtask

  initial begin
    void'($urandom(32'd2468));
    repeat (3) begin
      @(negedge clk);
      chk(baud_tick == 1'b0, "R1 reset", baud_tick, 0);
    end
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(baud_tick == 1'b0, "R1 first", baud_tick, 0);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk(baud_tick == 1'b1, "R1 default", baud_tick, 1);
    end

    program_and_check(5, 8'h10, 4, "R2 integer");
    program_and_check(300, 8'h10, 2, "R2 two-byte");
    program_and_check(0, 8'h10, 4, "R3 zero-div");
    program_and_check(4, 8'h31, 7, "R4 R7 fraction");
    program_and_check(1, 8'h21, 5, "R5 clamp");
    program_and_check(0, 8'h32, 5, "R5 zero clamp");
    program_and_check(3, 8'h55, 3, "R6 equal");
    program_and_check(3, 8'h13, 3, "R6 R7 swapped");
    program_and_check(3, 8'h04, 3, "R6 mul0");

    // R8: locked divisor writes leave the running sequence intact
    program_and_check(5, 8'h10, 2, "R8 setup");
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h01);
    expect_gap(2, "R8 locked");
    expect_gap(5, "R8 locked");
    expect_gap(5, "R8 locked");

    // R10: pulse width with a large divisor
    program_and_check(7, 8'h10, 1, "R10 setup");
    @(posedge clk); @(negedge clk);
    chk(baud_tick == 1'b0, "R10 width", baud_tick, 0);

    for (int k = 0; k < 20; k++) begin
      int dl = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 40)) : int'($urandom_range(0, 9));
      logic [7:0] fr = 8'($urandom_range(0, 255));
      program_and_check(dl, fr, 12, "R4 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule